// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects an on-chip request port to an external asynchronous static RAM. The RAM holds 262,144 words of 16 bits, takes 18 address bits, and has a shared bidirectional data bus. Requests arrive on a valid/ready port and carry a read/write flag, an address, write data and one enable per byte lane. The controller runs each request as one memory cycle. It drives the memory's active-low chip select, write strobe, output enable and per-lane enables. It also owns the drive enable of the data pads. Read data comes back on a response port with a one-cycle valid strobe.

The controller works in clock cycles. The read access time, the write-strobe width and the bus float time are given in nanoseconds, together with the clock period. Each one is rounded up to whole cycles, with a minimum of one. The data bus is split into an output word, an output enable and an input word, so the pad ring can build the tri-state buffer.

Back-pressure: `req_ready` is high only while no memory cycle is running. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge. The response port has no back-pressure: `rsp_valid` is a pulse that the consumer must take in that cycle.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are high, `mem_dq_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: In a write, chip select and the address go active at least one cycle before `mem_we_n` falls. `mem_we_n` stays low for exactly ceil(PWE_NS/CLK_NS) cycles. `mem_oe_n` stays high throughout. `mem_we_n` rises while chip select is still low.
- R3: Lane enables are active low: `mem_be_n[0]` gates data bits 7:0 and `mem_be_n[1]` gates bits 15:8, following `req_be[0]` and `req_be[1]`. A lane whose enable is off keeps its old memory contents after a write.
- R4: `mem_dq_oe` goes high only after `mem_oe_n` has been high for at least ceil(HZ_NS/CLK_NS) consecutive cycles. It is never high while the memory may still drive the bus.
- R5: The write data is driven, unchanged, from the cycle in which `mem_we_n` falls through at least the cycle in which it rises again.
- R6: In a read, `mem_oe_n` is low with `mem_we_n` high for exactly ceil(ACC_NS/CLK_NS) cycles. Data is sampled on the last of these cycles. `rsp_valid` is high for exactly one cycle, in the following cycle. Lanes whose enable was off return zero.
- R7: `req_ready` is low from the cycle after a request is accepted until the memory cycle has finished. Chip select is never low while `req_ready` is high.
- R8: The address and lane enables stay constant while chip select is low. A read returns the last data written to that address, including a read issued straight after the write and at the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Memory lane enables, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 16 | Data from the memory pads |

## Verification
The bench accepts a read on a clock edge and expects `rsp_valid` on the falling edge that lies the read-access count plus one cycles later. It counts falling edges from acceptance and checks for the pulse at exactly that count. It also checks that the pulse is gone one edge later.

A behavioural memory model samples the pins on every falling edge, half a cycle clear of the edges where the controller changes them. It measures the write-strobe width and where the strobe sits relative to chip select. It commits a write only on the edge where the strobe rises, and checks on that same edge that the data is still driven and unchanged.

The model keeps the bus driven for the float count after its output enable is released. A drive enable that comes even one cycle early therefore shows up as contention on a falling edge. Every scenario then reads the data back through the request port.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_READ,
    SC_WSETUP,
    SC_WPULSE,
    SC_WHOLD
  } sc_state_e;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_turnaround.sv
module sram_ctrl_turnaround #(
  parameter int unsigned TURN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_drive_req,  // memory output enable asserted this cycle
  output logic bus_free
);
  localparam int unsigned W = $clog2(TURN + 1);
  logic [W-1:0] quiet;

  // Reloaded while the memory may drive; counts down once it is released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              quiet <= '0;
    else if (mem_drive_req)  quiet <= W'(TURN);
    else if (quiet != '0)    quiet <= quiet - 1'b1;
  end

  assign bus_free = (quiet == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WE_CYC = 1,
  parameter int unsigned TW     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          bus_free,
  input  logic          tmr_expired,
  output sc_state_e     state,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          accept,
  output logic          capture
);
  sc_state_e state_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SC_IDLE;
    else        state <= state_nxt;
  end

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    capture   = 1'b0;
    unique case (state)
      SC_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_nxt = SC_WSETUP;
          end else begin
            state_nxt = SC_READ;
            tmr_load  = 1'b1;
            tmr_val   = TW'(RD_CYC - 1);
          end
        end
      end
      SC_READ: begin
        if (tmr_expired) begin
          capture   = 1'b1;
          state_nxt = SC_IDLE;
        end
      end
      SC_WSETUP: begin
        if (bus_free) begin
          state_nxt = SC_WPULSE;
          tmr_load  = 1'b1;
          tmr_val   = TW'(WE_CYC - 1);
        end
      end
      SC_WPULSE: begin
        if (tmr_expired) state_nxt = SC_WHOLD;
      end
      SC_WHOLD:  state_nxt = SC_IDLE;
      default:   state_nxt = SC_IDLE;
    endcase
  end
endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata[i*LANE_W +: LANE_W] <= '0;
      else if (capture) rdata[i*LANE_W +: LANE_W] <= lane_en[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= capture;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned ACC_NS = 12,
  parameter int unsigned PWE_NS = 10,
  parameter int unsigned HZ_NS  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_be,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [LANES-1:0]        mem_be_n,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_in
);
  localparam int unsigned DATA_W   = LANES * LANE_W;
  localparam int unsigned RD_CYC   = ns_to_cycles(ACC_NS, CLK_NS);
  localparam int unsigned WE_CYC   = ns_to_cycles(PWE_NS, CLK_NS);
  localparam int unsigned TURN_CYC = ns_to_cycles(HZ_NS, CLK_NS);
  localparam int unsigned TMAX     = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int unsigned TW       = (TMAX > 1) ? $clog2(TMAX) : 1;

  sc_state_e         state;
  logic              tmr_load, tmr_expired, accept, capture, bus_free;
  logic [TW-1:0]     tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;

  sram_ctrl_fsm #(.RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .bus_free(bus_free), .tmr_expired(tmr_expired), .state(state),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept), .capture(capture)
  );

  sram_ctrl_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sram_ctrl_turnaround #(.TURN(TURN_CYC)) u_turn (
    .clk(clk), .rst_n(rst_n), .mem_drive_req(state == SC_READ), .bus_free(bus_free)
  );

  sram_ctrl_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .capture(capture), .lane_en(be_q),
    .dq_in(mem_dq_in), .rdata(rsp_rdata), .rvalid(rsp_valid)
  );

  // Request fields held for the whole memory cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  assign req_ready  = (state == SC_IDLE);
  assign mem_ce_n   = (state == SC_IDLE);
  assign mem_oe_n   = (state != SC_READ);
  assign mem_we_n   = (state != SC_WPULSE);
  assign mem_dq_oe  = (state == SC_WPULSE) || (state == SC_WHOLD);
  assign mem_be_n   = mem_ce_n ? '1 : ~be_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned TURN   = 1,
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  localparam int unsigned HW = $clog2(TURN + 1);
  logic [HW-1:0] oe_high_run;

  // Saturating count of completed cycles with the memory output disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      oe_high_run <= HW'(TURN);
    else if (!mem_oe_n)              oe_high_run <= '0;
    else if (oe_high_run < HW'(TURN)) oe_high_run <= oe_high_run + 1'b1;
  end

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));
  a_r2_select_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n));
  a_r2_rise_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (oe_high_run >= HW'(TURN)));
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .TURN(TURN_CYC), .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
  // 20 ns clock; overrides give 3 access cycles, 2 strobe cycles, 3 float cycles
  localparam int RD = 3;
  localparam int WE = 2;
  localparam int TURN = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [15:0] mdl_mem [int];
  logic [15:0] exp_mem [int];
  logic        drv = 1'b0;
  logic [15:0] mdata = '0;
  int          lg = 0, rd_run = 0, wr_run = 0;
  logic        prev_we = 1'b1, prev_ce = 1'b1;
  logic [15:0] wr_data = '0;

  always #10 clk = ~clk;

  sram_ctrl #(.CLK_NS(20), .ACC_NS(45), .PWE_NS(30), .HZ_NS(50)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  assign mem_dq_in = mem_dq_oe ? mem_dq_out : (drv ? mdata : 16'h0000);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_mem(input logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  // Behavioural memory, sampled on falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      logic reading;
      logic [15:0] cur;
      reading = !mem_ce_n && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);
      if (reading) begin
        rd_run++;
        lg = TURN;
        drv = 1'b1;
        cur = rd_mem(mdl_mem, int'(mem_addr));
        if (rd_run >= RD)
          mdata = {mem_be_n[1] ? 8'hEE : cur[15:8], mem_be_n[0] ? 8'hEE : cur[7:0]};
        else
          mdata = 16'hBAD5;
      end else begin
        rd_run = 0;
        if (lg > 0) begin drv = 1'b1; lg--; end
        else drv = 1'b0;
      end
      if (drv && mem_dq_oe)
        chk(1'b0, "R4", "bus contention", 32'(mem_dq_oe), 32'd0);
      if (!mem_ce_n && !mem_we_n) begin
        if (prev_we) chk(!prev_ce, "R2", "select before strobe", 32'(prev_ce), 32'd0);
        if (!mem_oe_n) chk(1'b0, "R2", "oe low during write", 32'(mem_oe_n), 32'd1);
        if (!mem_dq_oe) chk(1'b0, "R5", "data not driven in strobe", 32'(mem_dq_oe), 32'd1);
        wr_run++;
        wr_data = mem_dq_out;
      end
      if (!prev_we && mem_we_n) begin
        chk(wr_run == WE, "R2", "strobe width", 32'(wr_run), 32'(WE));
        chk(!mem_ce_n, "R2", "select held at strobe end", 32'(mem_ce_n), 32'd0);
        chk(mem_dq_oe && mem_dq_out == wr_data, "R5", "data hold",
            {15'd0, mem_dq_oe, mem_dq_out}, {15'd0, 1'b1, wr_data});
        cur = rd_mem(mdl_mem, int'(mem_addr));
        if (!mem_be_n[0]) cur[7:0] = wr_data[7:0];
        if (!mem_be_n[1]) cur[15:8] = wr_data[15:8];
        mdl_mem[int'(mem_addr)] = cur;
        wr_run = 0;
      end
      prev_we = mem_we_n;
      prev_ce = mem_ce_n;
    end
  end

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7", "ready low after accept", 32'(req_ready), 32'd0);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] e;
    issue(1'b1, a, d, be);
    e = rd_mem(exp_mem, int'(a));
    if (be[0]) e[7:0] = d[7:0];
    if (be[1]) e[15:8] = d[15:8];
    exp_mem[int'(a)] = e;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be, input string req);
    int n;
    logic [15:0] e;
    issue(1'b0, a, 16'h0, be);
    n = 1;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    chk(n == RD + 1, "R6", "read latency", 32'(n), 32'(RD + 1));
    e = rd_mem(exp_mem, int'(a));
    e = {be[1] ? e[15:8] : 8'h00, be[0] ? e[7:0] : 8'h00};
    chk(rsp_rdata == e, req, "read data", 32'(rsp_rdata), 32'(e));
    @(negedge clk);
    chk(!rsp_valid, "R6", "valid pulse one cycle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, "R1", "controls in reset",
        32'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}), 32'h1f);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_dq_oe, "R1", "ready/valid/oe after reset",
        32'({req_ready, rsp_valid, mem_dq_oe}), 32'b100);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, "R1", "controls after reset",
        32'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}), 32'h1f);
  endtask

  task automatic t_basic;
    do_write(18'h00010, 16'h1234, 2'b11);
    do_read(18'h00010, 2'b11, "R8");
  endtask

  task automatic t_lanes;  // R3
    do_write(18'h00020, 16'hA5C3, 2'b11);
    do_write(18'h00020, 16'hFF7E, 2'b01);
    do_read(18'h00020, 2'b11, "R3");
    do_write(18'h00020, 16'h9900, 2'b10);
    do_read(18'h00020, 2'b11, "R3");
  endtask

  task automatic t_partial_read;  // R6 disabled lanes zero
    do_write(18'h00031, 16'hBEEF, 2'b11);
    do_read(18'h00031, 2'b01, "R6");
    do_read(18'h00031, 2'b10, "R6");
  endtask

  task automatic t_turnaround;  // R4: write right after read, read right after write
    int e0;
    e0 = errors;
    do_read(18'h00010, 2'b11, "R8");
    do_write(18'h00040, 16'h0F0F, 2'b11);
    do_read(18'h00040, 2'b11, "R8");
    chk(errors == e0, "R4", "no contention in turnaround", 32'(errors - e0), 32'd0);
  endtask

  task automatic t_edges;  // R8 address extremes
    do_write(18'h3FFFF, 16'hC001, 2'b11);
    do_write(18'h00000, 16'h5EED, 2'b11);
    do_read(18'h3FFFF, 2'b11, "R8");
    do_read(18'h00000, 2'b11, "R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_lanes();
    t_partial_read();
    t_turnaround();
    t_edges();
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule